// File: doc/BRIEF.md
# Scan-Wrapped Two-Bit State Machine with Test Sequencer

This block holds a small two-bit state machine whose two state flip-flops are mux-type scan cells. In run mode the cells capture the next-state logic, which is driven by two functional inputs `a` and `b`. In test mode the same cells form one serial shift register. A single test-control net selects the mode.

A built-in sequencer carries out one complete scan test when `start` is pulsed. It shifts a two-bit state pattern into the chain and then drops to run mode for exactly one capture clock, using the supplied `a`/`b` stimulus. It then returns to test mode, shifts the captured state out, and presents it on a parallel response bus with a one-cycle `done` pulse.

Sequencer states:
- `SQ_IDLE`: run mode. The core steps freely on `func_a`/`func_b`.
- `SQ_LOAD`: shifts the pattern in.
- `SQ_CAPTURE`: one run-mode clock.
- `SQ_UNLOAD`: shifts the result out.
- `SQ_REPORT`: pulses `done`.

Sequencer transitions:
- IDLE→LOAD on `start`.
- LOAD→LOAD until the last bit has been shifted, then LOAD→CAPTURE.
- CAPTURE→UNLOAD always.
- UNLOAD→UNLOAD until the last bit has been read, then UNLOAD→REPORT.
- REPORT→IDLE always.
- Reset from any state goes to IDLE.

Top module: `scan_fsm_harness`

## Requirements
- R1: A synchronous active-high `rst` clears both state bits and returns the sequencer to idle. In idle, `test_mode` is 0 and `done` is 0.
- R2: In run mode the next value of state bit 1 is q1·!q0 + !a·q1 + b·q0.
- R3: In run mode the next value of state bit 0 is b·!q1·!q0 + !a·b·!q1 + !a·b·!q0.
- R4: In test mode the chain order is scan-in → q1 → q0 → `scan_out`, so `scan_out` always shows q0. The sequencer shifts `pat[0]` first and `pat[1]` second, which leaves q1=`pat[1]` and q0=`pat[0]`. Mid-test, `state_o[1]` shows q1 and `state_o[0]` shows q0.
- R5: The order of a scan test is fixed. On the edge that samples `start` in idle, the sequencer enters test mode. It then gives two shift clocks and exactly one run-mode capture clock (`test_mode`=0), followed by two shift clocks. `done` is high for one cycle, beginning right after the sixth edge counted from the edge that sampled `start`.
- R6: While `done` is high, `resp[1]` holds the captured q1 and `resp[0]` holds the captured q0. `resp` keeps its value until the next test unloads.
- R7: The capture clock uses `stim_a`/`stim_b` as they were sampled with `start`. During a test, `func_a`/`func_b` have no effect on the response or its timing.
- R8: In idle the core advances on every clock using `func_a` as `a` and `func_b` as `b`.
- R9: A `start` pulse that arrives while a test is running is ignored and does not change the timing of `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a scan test when idle |
| pat | input | 2 | State pattern to load (bit 1 → q1, bit 0 → q0) |
| stim_a | input | 1 | `a` value applied during the capture clock |
| stim_b | input | 1 | `b` value applied during the capture clock |
| func_a | input | 1 | `a` input in run mode while idle |
| func_b | input | 1 | `b` input in run mode while idle |
| done | output | 1 | One-cycle pulse when the response is valid |
| resp | output | 2 | Unloaded captured state (bit 1 = q1, bit 0 = q0) |
| state_o | output | 2 | Current state flip-flops {q1, q0} |
| test_mode | output | 1 | Test-control level (1 = shift) |
| scan_out | output | 1 | Serial chain output |

## Verification
The hardest case to reach from the ports is a single capture clock from every one of the sixteen combinations of state and input. In normal operation the state is reached only by walking the machine, and some states are hard to reach that way. The bench therefore uses the sequencer itself: each pattern is loaded directly through the chain, and the response comes back through the unload. While each test runs, the bench toggles the functional inputs and sends a stray `start`, so that a leak of either into the capture or the timing would change the result. A reset in the middle of a test checks that the sequencer aborts cleanly.

// File: rtl/scan_fsm_pkg.sv
`timescale 1ns/1ps
package scan_fsm_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE    = 3'd0,
        SQ_LOAD    = 3'd1,
        SQ_CAPTURE = 3'd2,
        SQ_UNLOAD  = 3'd3,
        SQ_REPORT  = 3'd4
    } seq_state_t;
endpackage

// File: rtl/fsm_next_logic.sv
`timescale 1ns/1ps
module fsm_next_logic (
    input  logic       a,
    input  logic       b,
    input  logic [1:0] q,
    output logic [1:0] d
);
    logic shared_c;

    always_comb begin
        // common factor used by both next-state bits
        shared_c = ~q[0] | ~a;
        d[1] = (shared_c & q[1]) | (b & q[0]);
        d[0] = b & ((shared_c & ~q[1]) | (~a & ~q[0]));
    end
endmodule

// File: rtl/scan_cell.sv
`timescale 1ns/1ps
module scan_cell (
    input  logic clk,
    input  logic rst,
    input  logic tc,
    input  logic d,
    input  logic sd,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else
            q <= tc ? sd : d;
    end

    a_r4_shift_takes_sd: assert property (@(posedge clk) disable iff (rst)
        tc |=> (q == $past(sd)));
    a_r2_run_takes_d: assert property (@(posedge clk) disable iff (rst)
        !tc |=> (q == $past(d)));
endmodule

// File: rtl/scan_chain.sv
`timescale 1ns/1ps
module scan_chain #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tc,
    input  logic         si,
    input  logic [N-1:0] d,
    output logic [N-1:0] q,
    output logic         so
);
    logic [N:0] link;

    assign link[N] = si;
    assign so      = q[0];

    for (genvar i = N - 1; i >= 0; i--) begin : g_cell
        assign link[i] = q[i];
        scan_cell u_cell (
            .clk(clk),
            .rst(rst),
            .tc (tc),
            .d  (d[i]),
            .sd (link[i+1]),
            .q  (q[i])
        );
    end
endmodule

// File: rtl/scan_sequencer.sv
`timescale 1ns/1ps
module scan_sequencer
    import scan_fsm_pkg::*;
#(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [N-1:0] pat,
    input  logic         stim_a,
    input  logic         stim_b,
    input  logic         func_a,
    input  logic         func_b,
    input  logic         so,
    output logic         tc,
    output logic         si,
    output logic         core_a,
    output logic         core_b,
    output logic         done,
    output logic [N-1:0] resp
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    seq_state_t    state, state_nx;
    logic [CW-1:0] cnt;
    logic [N-1:0]  pat_q;
    logic          stim_a_q, stim_b_q;
    logic [N-1:0]  rsp_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= SQ_IDLE;
        else     state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_IDLE:    if (start) state_nx = SQ_LOAD;
            SQ_LOAD:    if (cnt == LAST) state_nx = SQ_CAPTURE;
            SQ_CAPTURE: state_nx = SQ_UNLOAD;
            SQ_UNLOAD:  if (cnt == LAST) state_nx = SQ_REPORT;
            SQ_REPORT:  state_nx = SQ_IDLE;
            default:    state_nx = SQ_IDLE;
        endcase
    end

    // data registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            pat_q    <= '0;
            stim_a_q <= 1'b0;
            stim_b_q <= 1'b0;
            rsp_q    <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    cnt <= '0;
                    if (start) begin
                        pat_q    <= pat;
                        stim_a_q <= stim_a;
                        stim_b_q <= stim_b;
                    end
                end
                SQ_LOAD:    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
                SQ_CAPTURE: cnt <= '0;
                SQ_UNLOAD: begin
                    rsp_q[cnt] <= so;
                    cnt        <= (cnt == LAST) ? '0 : cnt + 1'b1;
                end
                SQ_REPORT:  cnt <= '0;
                default:    cnt <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        tc     = 1'b0;
        si     = 1'b0;
        core_a = func_a;
        core_b = func_b;
        done   = 1'b0;
        unique case (state)
            SQ_IDLE: ;
            SQ_LOAD: begin
                tc = 1'b1;
                si = pat_q[cnt];
            end
            SQ_CAPTURE: begin
                core_a = stim_a_q;
                core_b = stim_b_q;
            end
            SQ_UNLOAD: tc = 1'b1;
            SQ_REPORT: done = 1'b1;
            default: ;
        endcase
    end

    assign resp = rsp_q;

    a_r5_single_capture: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_CAPTURE) |=> (state == SQ_UNLOAD && tc));
    a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_UNLOAD && start) |=> (state != SQ_LOAD));
    a_r6_resp_held: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_IDLE) |=> $stable(resp));
endmodule

// File: rtl/scan_fsm_harness.sv
`timescale 1ns/1ps
module scan_fsm_harness #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [N-1:0] pat,
    input  logic         stim_a,
    input  logic         stim_b,
    input  logic         func_a,
    input  logic         func_b,
    output logic         done,
    output logic [N-1:0] resp,
    output logic [N-1:0] state_o,
    output logic         test_mode,
    output logic         scan_out
);
    logic         tc, si, core_a, core_b;
    logic [N-1:0] q, d;

    fsm_next_logic u_logic (
        .a(core_a),
        .b(core_b),
        .q(q),
        .d(d)
    );

    scan_chain #(.N(N)) u_chain (
        .clk(clk),
        .rst(rst),
        .tc (tc),
        .si (si),
        .d  (d),
        .q  (q),
        .so (scan_out)
    );

    scan_sequencer #(.N(N)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .pat   (pat),
        .stim_a(stim_a),
        .stim_b(stim_b),
        .func_a(func_a),
        .func_b(func_b),
        .so    (scan_out),
        .tc    (tc),
        .si    (si),
        .core_a(core_a),
        .core_b(core_b),
        .done  (done),
        .resp  (resp)
    );

    assign state_o   = q;
    assign test_mode = tc;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (state_o == '0 && !test_mode && !done));
endmodule

// File: tb/scan_fsm_harness_test.sv
`timescale 1ns/1ps
module scan_fsm_harness_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] pat = 2'b00;
    logic       stim_a = 1'b0, stim_b = 1'b0;
    logic       func_a = 1'b0, func_b = 1'b0;
    logic       done;
    logic [1:0] resp, state_o;
    logic       test_mode, scan_out;

    int checks = 0;
    int failures = 0;
    logic [1:0] exp_q[$];
    logic finished = 1'b0;

    always #4 clk = ~clk;

    scan_fsm_harness uut (
        .clk(clk), .rst(rst), .start(start), .pat(pat),
        .stim_a(stim_a), .stim_b(stim_b), .func_a(func_a), .func_b(func_b),
        .done(done), .resp(resp), .state_o(state_o),
        .test_mode(test_mode), .scan_out(scan_out)
    );

    function automatic logic [1:0] model(input logic a, input logic b, input logic [1:0] s);
        logic q1, q0;
        q1 = s[1]; q0 = s[0];
        model[1] = (q1 & ~q0) | (~a & q1) | (b & q0);
        model[0] = (b & ~q1 & ~q0) | (~a & b & ~q1) | (~a & b & ~q0);
    endfunction

    task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops the expected response each time done is seen
    always @(negedge clk) begin
        if (done && !rst) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected done", {6'b0, resp}, 8'h0);
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                chk(resp == e, "R2/R3/R6 response", {6'b0, resp}, {6'b0, e});
            end
        end
    end

    // driver: one full scan test
    task automatic scan_run(input logic [1:0] p, input logic a, input logic b);
        exp_q.push_back(model(a, b, p));
        @(negedge clk);
        pat = p; stim_a = a; stim_b = b; start = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            start  = (k == 1);            // R9 stray start while busy
            func_a = ~a ^ k[0];           // R7 functional inputs wiggle
            func_b = ~func_b;
            stim_a = ~a; stim_b = ~b;      // R7 late stimulus change
            if (k == 1) chk(test_mode == 1'b1, "R4 shift mode", {7'b0, test_mode}, 8'h1);
            if (k == 2) begin
                chk(test_mode == 1'b0, "R5 capture mode", {7'b0, test_mode}, 8'h0);
                chk(state_o == p, "R4 loaded state", {6'b0, state_o}, {6'b0, p});
                chk(scan_out == p[0], "R4 scan_out is q0", {7'b0, scan_out}, {7'b0, p[0]});
            end
            if (k < 5) chk(done == 1'b0, "R5 done early", {7'b0, done}, 8'h0);
            else       chk(done == 1'b1, "R5 done timing", {7'b0, done}, 8'h1);
        end
        @(negedge clk);
        chk(done == 1'b0, "R5 done one cycle", {7'b0, done}, 8'h0);
        chk(resp == model(a, b, p), "R6 resp held", {6'b0, resp}, {6'b0, model(a, b, p)});
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(state_o == 2'b00, "R1 state", {6'b0, state_o}, 8'h0);
        chk(test_mode == 1'b0, "R1 test_mode", {7'b0, test_mode}, 8'h0);
        chk(done == 1'b0, "R1 done", {7'b0, done}, 8'h0);

        // R8 free-running functional mode
        for (int i = 0; i < 12; i++) begin
            logic [1:0] prev;
            func_a = i[0] ^ i[2];
            func_b = i[1] | i[3];
            prev = state_o;
            @(negedge clk);
            chk(state_o == model(func_a, func_b, prev), "R8 run step",
                {6'b0, state_o}, {6'b0, model(func_a, func_b, prev)});
        end

        // R2 R3 sweep of all 16 combinations through scan
        for (int v = 0; v < 16; v++) begin
            logic [3:0] w;
            w = 4'(v);
            scan_run(w[1:0], w[3], w[2]);
        end

        // R1 reset in the middle of a test
        @(negedge clk);
        pat = 2'b11; stim_a = 1'b0; stim_b = 1'b1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(state_o == 2'b00, "R1 abort state", {6'b0, state_o}, 8'h0);
        chk(test_mode == 1'b0, "R1 abort mode", {7'b0, test_mode}, 8'h0);
        func_a = 1'b1; func_b = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(done == 1'b0, "R1 no done after abort", {7'b0, done}, 8'h0);
        end

        // one more test after recovery
        scan_run(2'b10, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all responses seen", 8'(exp_q.size()), 8'h0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule